// File: doc/BRIEF.md
# Strobed Parallel Port Handshake Controller

This block runs one byte-wide parallel port for a processor bus. With handshaking off it is a plain port. As an input it returns whatever the pins carry when the processor reads it. As an output it drives the last byte the processor wrote. With handshaking on, the port exchanges data with a peripheral through an active-low strobe input and two flag outputs: buffer full and interrupt request. What these flags mean depends on the direction.

For a strobed input, the peripheral drops the strobe to latch the pin data. That raises buffer full. Releasing the strobe sets the interrupt request. A processor read of the port clears both flags. For a strobed output, a processor write loads the byte, raises buffer full and withdraws the request. The peripheral's strobe then takes the byte: its falling edge clears buffer full and its rising edge sets the request. The strobe is asynchronous. The data capture happens on the strobe's own falling edge. The flag updates wait for a synchronised copy of the strobe, so they follow the strobe by a fixed number of system clocks. The interrupt output is the request gated by an enable bit. The raw request, buffer full and the enable are always visible on the status outputs.

Top module: `hs_port`

## Requirements
- R1: While reset is asserted, and after it is released with no other stimulus, pin_oe, pin_out, buf_full, intr and every status output are 0.
- R2: pin_oe equals the value dir_out had at the previous clock edge (1 = output, 0 = input). pin_out changes only at a clock edge where cpu_wr is 1, and it then takes cpu_wdata. This holds whatever the mode.
- R3: With hs_en = 0 and dir_out = 0, cpu_rdata equals pin_in combinationally.
- R4: With hs_en = 1 and dir_out = 0, each falling edge of stb_n stores pin_in. cpu_rdata returns that stored byte even after the pins change. With dir_out = 1, cpu_rdata returns the output register in either mode.
- R5: With hs_en = 1, a level change on stb_n reaches the flags at the (SYNC_STAGES+1)-th rising clock edge that samples the new level. This is the third edge for the default of 2.
- R6: Strobed input: a synchronised strobe fall sets buffer full. A synchronised strobe rise sets the request. A cpu_rd clears both. When a strobe event and a read occur at the same edge, the strobe event wins.
- R7: Strobed output: a cpu_wr sets buffer full and clears the request at that clock edge.
- R8: Strobed output: a synchronised strobe fall clears buffer full and a synchronised strobe rise sets the request. A cpu_wr at the same edge overrides either event.
- R9: intr equals the request AND int_en. With int_en = 0, intr stays 0 while stat_req still reports the tracked request.
- R10: stat_req, stat_full and stat_int_en report the request flag, the buffer-full flag and int_en. buf_full equals stat_full.
- R11: While hs_en = 0, both flags are 0 from the next clock edge on. Strobe activity has no effect on them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_out | input | 1 | Port direction, 1 = output |
| hs_en | input | 1 | Enables the strobed handshake |
| int_en | input | 1 | Interrupt enable |
| cpu_rd | input | 1 | One-clock read pulse for the data register |
| cpu_wr | input | 1 | One-clock write pulse for the data register |
| cpu_wdata | input | DATA_W | Write data |
| cpu_rdata | output | DATA_W | Read data |
| stb_n | input | 1 | Peripheral strobe, active low, asynchronous |
| pin_in | input | DATA_W | Pin input values |
| pin_out | output | DATA_W | Pin output values |
| pin_oe | output | 1 | Pin output enable |
| buf_full | output | 1 | Buffer-full handshake line |
| intr | output | 1 | Interrupt request line |
| stat_req | output | 1 | Status: interrupt request flag |
| stat_full | output | 1 | Status: buffer-full flag |
| stat_int_en | output | 1 | Status: interrupt enable |

## Verification
The hardest case to reach is a strobe event that lands on the same clock edge as a processor read or write. The strobe is asynchronous and passes through the synchroniser, so the collision only happens when the bus pulse is placed exactly SYNC_STAGES clocks after the strobe level is driven. The stimulus does this on purpose in both directions. A long random phase then mixes strobe pulses of random width with random reads, writes and mode changes. A behavioural model, built from a history queue of sampled strobe levels, is compared against every output on every clock.

// File: rtl/hs_port_pkg.sv
package hs_port_pkg;

    typedef enum logic [1:0] {
        PM_PLAIN_IN  = 2'b00,
        PM_PLAIN_OUT = 2'b01,
        PM_HS_IN     = 2'b10,
        PM_HS_OUT    = 2'b11
    } port_mode_e;

    typedef struct packed {
        logic full;
        logic req;
    } hs_flags_t;

    function automatic port_mode_e decode_mode(input logic hs_en, input logic dir_out);
        return port_mode_e'({hs_en, dir_out});
    endfunction

endpackage

// File: rtl/hs_strobe_sync.sv
module hs_strobe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stb_n,
    output logic stb_fall,
    output logic stb_rise
);

    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.chain = STAGES'({st_q.chain, stb_n});
        st_d.prev  = st_q.chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.chain <= '1;
            st_q.prev  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign stb_fall = st_q.prev & ~st_q.chain[STAGES-1];
    assign stb_rise = ~st_q.prev & st_q.chain[STAGES-1];

endmodule

// File: rtl/hs_flag_ctl.sv
module hs_flag_ctl
    import hs_port_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  port_mode_e mode,
    input  logic       cpu_rd,
    input  logic       cpu_wr,
    input  logic       stb_fall,
    input  logic       stb_rise,
    output hs_flags_t  flags
);

    hs_flags_t fl_d, fl_q;

    always_comb begin
        fl_d = fl_q;
        unique case (mode)
            PM_HS_IN: begin
                fl_d.full = (fl_q.full & ~cpu_rd) | stb_fall;
                fl_d.req  = (fl_q.req  & ~cpu_rd) | stb_rise;
            end
            PM_HS_OUT: begin
                if (cpu_wr) begin
                    fl_d.full = 1'b1;
                    fl_d.req  = 1'b0;
                end else begin
                    if (stb_fall) fl_d.full = 1'b0;
                    if (stb_rise) fl_d.req  = 1'b1;
                end
            end
            default: begin
                fl_d.full = 1'b0;
                fl_d.req  = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fl_q <= '0;
        end else begin
            fl_q <= fl_d;
        end
    end

    assign flags = fl_q;

    AST_IN_FALL_SETS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == PM_HS_IN && stb_fall) |=> flags.full); // R6

    AST_IN_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == PM_HS_IN && cpu_rd && !stb_fall && !stb_rise) |=> (!flags.full && !flags.req)); // R6

    AST_OUT_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == PM_HS_OUT && cpu_wr) |=> (flags.full && !flags.req)); // R7

    AST_PLAIN_NO_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == PM_PLAIN_IN || mode == PM_PLAIN_OUT) |=> (!flags.full && !flags.req)); // R11

endmodule

// File: rtl/hs_data_path.sv
module hs_data_path
    import hs_port_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  port_mode_e        mode,
    input  logic              stb_n,
    input  logic [DATA_W-1:0] pin_in,
    input  logic              cpu_wr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic [DATA_W-1:0] pin_out,
    output logic              pin_oe
);

    typedef struct packed {
        logic [DATA_W-1:0] outreg;
        logic              oe;
    } dp_t;

    dp_t dp_d, dp_q;
    logic [DATA_W-1:0] snap_q;

    always_comb begin
        dp_d    = dp_q;
        dp_d.oe = (mode == PM_PLAIN_OUT) || (mode == PM_HS_OUT);
        if (cpu_wr) dp_d.outreg = cpu_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dp_q <= '0;
        end else begin
            dp_q <= dp_d;
        end
    end

    // Peripheral data is taken in the strobe's own domain; the flags that
    // announce it arrive later through the synchroniser.
    always_ff @(negedge stb_n or negedge rst_n) begin
        if (!rst_n) begin
            snap_q <= '0;
        end else begin
            snap_q <= pin_in;
        end
    end

    always_comb begin
        unique case (mode)
            PM_PLAIN_IN: cpu_rdata = pin_in;
            PM_HS_IN:    cpu_rdata = snap_q;
            default:     cpu_rdata = dp_q.outreg;
        endcase
    end

    assign pin_out = dp_q.outreg;
    assign pin_oe  = dp_q.oe;

    AST_PINS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_wr |=> $stable(pin_out)); // R2

endmodule

// File: rtl/hs_port.sv
module hs_port
    import hs_port_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dir_out,
    input  logic              hs_en,
    input  logic              int_en,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    input  logic              stb_n,
    input  logic [DATA_W-1:0] pin_in,
    output logic [DATA_W-1:0] pin_out,
    output logic              pin_oe,
    output logic              buf_full,
    output logic              intr,
    output logic              stat_req,
    output logic              stat_full,
    output logic              stat_int_en
);

    port_mode_e mode;
    hs_flags_t  flags;
    logic       stb_fall;
    logic       stb_rise;

    assign mode = decode_mode(hs_en, dir_out);

    hs_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .stb_n    (stb_n),
        .stb_fall (stb_fall),
        .stb_rise (stb_rise)
    );

    hs_flag_ctl u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode),
        .cpu_rd   (cpu_rd),
        .cpu_wr   (cpu_wr),
        .stb_fall (stb_fall),
        .stb_rise (stb_rise),
        .flags    (flags)
    );

    hs_data_path #(.DATA_W(DATA_W)) u_data (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode),
        .stb_n     (stb_n),
        .pin_in    (pin_in),
        .cpu_wr    (cpu_wr),
        .cpu_wdata (cpu_wdata),
        .cpu_rdata (cpu_rdata),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe)
    );

    assign buf_full    = flags.full;
    assign intr        = flags.req & int_en;
    assign stat_req    = flags.req;
    assign stat_full   = flags.full;
    assign stat_int_en = int_en;

    AST_OE_TRACKS_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (pin_oe == $past(dir_out))); // R2

    AST_MASKED_NO_INTR: assert property (@(posedge clk) disable iff (!rst_n)
        (!int_en && stat_req) |-> !intr); // R9

endmodule

// File: tb/hs_port_bench.sv
`timescale 1ns/100ps
module hs_port_bench;

    localparam int W = 8;
    localparam int N = 2;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         dir_out = 1'b0, hs_en = 1'b0, int_en = 1'b0;
    logic         cpu_rd = 1'b0, cpu_wr = 1'b0;
    logic [W-1:0] cpu_wdata = '0;
    logic [W-1:0] cpu_rdata;
    logic         stb_n = 1'b1;
    logic [W-1:0] pin_in = '0;
    logic [W-1:0] pin_out;
    logic         pin_oe, buf_full, intr, stat_req, stat_full, stat_int_en;

    int vectors = 0;
    int fails   = 0;
    int cycles  = 0;
    string tag  = "R1";

    always #2.5 clk = ~clk;

    hs_port #(.DATA_W(W), .SYNC_STAGES(N)) u_hs_port (
        .clk(clk), .rst_n(rst_n), .dir_out(dir_out), .hs_en(hs_en), .int_en(int_en),
        .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .stb_n(stb_n), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .buf_full(buf_full), .intr(intr), .stat_req(stat_req), .stat_full(stat_full),
        .stat_int_en(stat_int_en)
    );

    // behavioural reference
    int m_out = 0, m_oe = 0, m_full = 0, m_req = 0, m_snap = 0;
    int hist[$];

    task automatic chk(string req, string nm, int act, int exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, nm, act, exp, $time);
        end
    endtask

    always @(negedge stb_n) if (rst_n) m_snap = int'(pin_in);

    always @(posedge clk) begin
        int prev_s, cur_s, fall, rise;
        if (!rst_n) begin
            m_out = 0; m_oe = 0; m_full = 0; m_req = 0; m_snap = 0;
            hist.delete();
            for (int i = 0; i <= N; i++) hist.push_back(1);
        end else begin
            prev_s = hist[0];
            cur_s  = hist[1];
            fall = (prev_s == 1 && cur_s == 0);
            rise = (prev_s == 0 && cur_s == 1);
            if (!hs_en) begin
                m_full = 0; m_req = 0;
            end else if (!dir_out) begin
                m_full = ((m_full != 0 && !cpu_rd) || fall != 0) ? 1 : 0;
                m_req  = ((m_req  != 0 && !cpu_rd) || rise != 0) ? 1 : 0;
            end else if (cpu_wr) begin
                m_full = 1; m_req = 0;
            end else if (fall != 0) begin
                m_full = 0;
            end else if (rise != 0) begin
                m_req = 1;
            end
            if (cpu_wr) m_out = int'(cpu_wdata);
            m_oe = int'(dir_out);
            void'(hist.pop_front());
            hist.push_back(int'(stb_n));
        end
        #1;
        cycles++;
        chk("R2",  "pin_oe",  int'(pin_oe),  m_oe);
        chk("R2",  "pin_out", int'(pin_out), m_out);
        chk(tag,   "buf_full", int'(buf_full), m_full);
        chk("R10", "stat_full", int'(stat_full), m_full);
        chk("R10", "stat_req",  int'(stat_req),  m_req);
        chk("R9",  "intr", int'(intr), m_req & int'(int_en));
        chk("R10", "stat_int_en", int'(stat_int_en), int'(int_en));
        if (dir_out)     chk("R4", "rdata_out", int'(cpu_rdata), m_out);
        else if (hs_en)  chk("R4", "rdata_snap", int'(cpu_rdata), m_snap);
        else             chk("R3", "rdata_live", int'(cpu_rdata), int'(pin_in));
    end

    task automatic step(); @(negedge clk); endtask
    task automatic steps(int n); for (int i = 0; i < n; i++) step(); endtask

    initial begin
        #200000;
        fails++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        // R1: reset state
        steps(4);
        chk("R1", "oe_rst", int'(pin_oe), 0);
        chk("R1", "out_rst", int'(pin_out), 0);
        chk("R1", "flags_rst", int'({buf_full, intr, stat_req}), 0);
        rst_n = 1'b1;
        steps(3);
        chk("R1", "oe_after", int'(pin_oe), 0);
        chk("R1", "full_after", int'(stat_full), 0);

        // R2: plain output
        tag = "R2";
        dir_out = 1'b1; cpu_wdata = 8'h3C; cpu_wr = 1'b1; step(); cpu_wr = 1'b0;
        cpu_wdata = 8'hFF; steps(2);
        chk("R2", "plain_out", int'(pin_out), 'h3C);
        chk("R2", "plain_oe", int'(pin_oe), 1);

        // R3 / R11: plain input with strobe activity
        tag = "R11";
        dir_out = 1'b0; pin_in = 8'h91; step();
        chk("R3", "live_in", int'(cpu_rdata), 'h91);
        stb_n = 1'b0; steps(2); pin_in = 8'h17; stb_n = 1'b1; steps(4);
        chk("R3", "live_in2", int'(cpu_rdata), 'h17);
        chk("R11", "no_full", int'(buf_full), 0);
        chk("R11", "no_req", int'(stat_req), 0);

        // R4/R5/R6: strobed input
        tag = "R5";
        hs_en = 1'b1; int_en = 1'b1; pin_in = 8'hA5; step();
        stb_n = 1'b0; steps(2);
        chk("R5", "full_not_yet", int'(buf_full), 0);
        step();
        chk("R5", "full_third_edge", int'(buf_full), 1);
        pin_in = 8'h5A; stb_n = 1'b1; steps(4);
        chk("R4", "snap_held", int'(cpu_rdata), 'hA5);
        chk("R6", "intr_after_rise", int'(intr), 1);
        tag = "R6";
        cpu_rd = 1'b1; step(); cpu_rd = 1'b0;
        chk("R6", "rd_clears", int'({buf_full, stat_req}), 0);
        stb_n = 1'b0; steps(2); cpu_rd = 1'b1; step(); cpu_rd = 1'b0;
        chk("R6", "fall_beats_rd", int'(buf_full), 1);
        stb_n = 1'b1; steps(4);

        // R9: masked interrupt
        tag = "R9";
        cpu_rd = 1'b1; step(); cpu_rd = 1'b0; int_en = 1'b0;
        stb_n = 1'b0; steps(2); stb_n = 1'b1; steps(4);
        chk("R9", "masked_intr", int'(intr), 0);
        chk("R9", "req_tracked", int'(stat_req), 1);
        int_en = 1'b1; step();
        chk("R9", "unmasked_intr", int'(intr), 1);

        // R7/R8: strobed output
        tag = "R7";
        dir_out = 1'b1; cpu_wdata = 8'hC3; cpu_wr = 1'b1; step(); cpu_wr = 1'b0;
        chk("R7", "wr_full", int'(buf_full), 1);
        chk("R7", "wr_no_req", int'(stat_req), 0);
        tag = "R8";
        stb_n = 1'b0; steps(3);
        chk("R8", "fall_clears", int'(buf_full), 0);
        stb_n = 1'b1; steps(2); cpu_wdata = 8'h44; cpu_wr = 1'b1; step(); cpu_wr = 1'b0;
        chk("R8", "wr_beats_rise", int'({buf_full, stat_req}), 2);
        chk("R4", "rdata_out", int'(cpu_rdata), 'h44);
        stb_n = 1'b0; steps(3); stb_n = 1'b1; steps(3);
        chk("R8", "rise_sets_req", int'(intr), 1);

        // R11: leaving handshake mode
        tag = "R11";
        hs_en = 1'b0; step();
        chk("R11", "hs_off", int'({buf_full, stat_req}), 0);

        // random mix
        tag = "R6";
        begin
            int low_left = 0, high_left = 3;
            for (int i = 0; i < 4000; i++) begin
                logic falling;
                falling = 1'b0;
                if (stb_n) begin
                    if (high_left > 0) high_left--;
                    else begin stb_n = 1'b0; low_left = $urandom_range(0, 3); falling = 1'b1; end
                end else begin
                    if (low_left > 0) low_left--;
                    else begin stb_n = 1'b1; high_left = $urandom_range(0, 5); end
                end
                if (!falling) pin_in = W'($urandom);
                cpu_rd = ($urandom_range(0, 5) == 0);
                cpu_wr = ($urandom_range(0, 5) == 0);
                cpu_wdata = W'($urandom);
                if ($urandom_range(0, 60) == 0) dir_out = ~dir_out;
                if ($urandom_range(0, 80) == 0) hs_en = ~hs_en;
                if ($urandom_range(0, 20) == 0) int_en = ~int_en;
                step();
            end
        end
        cpu_rd = 1'b0; cpu_wr = 1'b0; stb_n = 1'b1;

        // R1: reset in mid-run
        steps(4);
        rst_n = 1'b0; steps(2);
        chk("R1", "mid_rst", int'({pin_oe, buf_full, stat_req, pin_out}), 0);
        rst_n = 1'b1; steps(2);

        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule